// File: doc/BRIEF.md
# Display Event Interrupt Controller

This block gathers interrupt events from two display pipes and from two other sources, a user-command completion event and a backlight-request event. It drives one level interrupt line to a host. Each pipe owns a small control word with two enable bits and two sticky status bits. One status bit records a vertical-blank start pulse and the other records a vertical-blank pulse. A pipe's chip-level source is the OR of its status bits whose enables are set.

At chip level, four word-addressed registers sit over the sources: a raw view of the sources, an enable word, a mask word and a latched identity word. An identity bit is captured only on a rising edge of its source. Capture happens only when the mask bit for that source is clear at the moment of that edge. An edge that meets a set mask is lost for good while the source stays high. Software reaches every register through a synchronous single-cycle read/write port. Read data appears one clock after the address is presented.

Identity bit map: bit 0 is the user-command event, bit 1 is the backlight request, and bit 2+p is pipe p. The same positions apply to the raw, enable and mask words. Word addresses: 0 raw (read-only), 1 enable, 2 mask, 3 identity, 4+p pipe p control. Pipe control layout: bit 0 enables vertical-blank start, bit 1 enables vertical-blank, bit 2 is the vertical-blank start status, bit 3 is the vertical-blank status.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the mask word reads all ones (0xF with two pipes), the enable word, the identity word and both pipe control words read 0, and the interrupt line is low.
- R2: A one-cycle pulse on a pipe's vertical-blank start or vertical-blank input sets the matching status bit (control bit 2 or 3) whatever the enable bits hold.
- R3: Writing a pipe control word loads bits 1:0 as enables and clears each status bit written as 1. A status bit written as 0 is unchanged.
- R4: When a status clear and a new pulse for the same bit fall in the same cycle, the status bit stays set.
- R5: Raw word bit 2+p reads the OR of pipe p's status bits whose enables are set. Bits 0 and 1 read the user and backlight input levels.
- R6: Identity bit 2+p sets one cycle after a rising edge of pipe p's source. A source that stays high does not set it again after it has been cleared.
- R7: An edge that occurs while the matching mask bit is 1 leaves the identity bit at 0. Clearing the mask afterwards does not set it while the source stays high.
- R8: Setting a mask bit does not clear an identity bit that is already set.
- R9: Writing the identity word clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: The interrupt line is high exactly when some identity bit and its enable bit are both 1.
- R11: A rising edge on the user-command input sets identity bit 0, and one on the backlight-request input sets identity bit 1, subject to their mask bits.
- R12: A read returns, one clock after the address is presented, the addressed register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbs_i | input | NPIPE | Vertical-blank start pulse per pipe |
| vb_i | input | NPIPE | Vertical-blank pulse per pipe |
| user_i | input | 1 | User-command completion event |
| blc_i | input | 1 | Backlight-request event |
| reg_addr_i | input | AW | Register word address |
| reg_wen_i | input | 1 | Write strobe |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with its defaults: two pipes, a 4-bit data word and a 3-bit address. This makes every source, mask and enable bit reachable in a short run and lets the random mix land edges on both pipes under every mask combination. The directed part covers cases a random run seldom hits. These include a clear and a pulse in the same cycle, and a masked edge followed by unmasking while the source is still high. Under these defaults the lost-edge rule and the retrigger rule can be seen directly at the ports.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  // identity / raw / enable / mask bit positions
  localparam int ID_USER  = 0;
  localparam int ID_BLC   = 1;
  localparam int ID_PIPE0 = 2;
  // word addresses
  localparam int A_RAW   = 0;
  localparam int A_EN    = 1;
  localparam int A_MASK  = 2;
  localparam int A_IDENT = 3;
  localparam int A_PIPE0 = 4;

  // sticky update: clear-by-one, a new event wins over the clear
  function automatic logic [1:0] sticky_next(logic [1:0] cur, logic [1:0] clr,
                                             logic [1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic pipe_source(logic [1:0] en, logic [1:0] st);
    return |(en & st);
  endfunction
endpackage

// File: rtl/disp_pipe_stat.sv
module disp_pipe_stat
  import disp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbs_i,
  input  logic       vb_i,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] ctl_o,
  output logic       src_o
);
  logic [1:0] en_q, st_q, evt_w, clr_w;

  assign evt_w = {vb_i, vbs_i};
  assign clr_w = wr_i ? wdata_i[3:2] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (wr_i) en_q <= wdata_i[1:0];
      st_q <= sticky_next(st_q, clr_w, evt_w);
    end
  end

  assign ctl_o = {st_q, en_q};
  assign src_o = pipe_source(en_q, st_q);

  // R2 R4
  sticky_vbs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_w[0] |=> st_q[0]);
  // R2 R4
  sticky_vb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_w[1] |=> st_q[1]);
  // R3
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q[0]) |-> $past(clr_w[0]));
endmodule

// File: rtl/disp_irq_ident.sv
module disp_irq_ident #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] ident_o,
  output logic            irq_o
);
  logic [NSRC-1:0] prev_q, ident_q, edge_w, catch_w;

  assign edge_w  = src_i & ~prev_q;
  assign catch_w = edge_w & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      ident_q <= '0;
    end else begin
      prev_q  <= src_i;
      ident_q <= (ident_q & ~clr_i) | catch_w;
    end
  end

  assign ident_o = ident_q;
  assign irq_o   = |(ident_q & en_i);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R6 R7 R11
    ident_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ident_q[i]) |-> $past(src_i[i] && !prev_q[i] && !mask_i[i]));
    // R8 R9
    ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ident_q[i]) && !$past(clr_i[i])) |-> ident_q[i]);
  end
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int NPIPE = 2,
  parameter int AW    = 3,
  parameter int DW    = (2 + NPIPE > 4) ? 2 + NPIPE : 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIPE-1:0] vbs_i,
  input  logic [NPIPE-1:0] vb_i,
  input  logic             user_i,
  input  logic             blc_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wen_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  localparam int NSRC = 2 + NPIPE;

  logic [NSRC-1:0] en_q, mask_q, raw_w, ident_w, iclr_w;
  logic [NPIPE-1:0] psrc_w;
  logic [3:0] pctl_w [NPIPE];
  logic [DW-1:0] rd_mux, rdata_q;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic pwr;
    assign pwr = reg_wen_i && (int'(reg_addr_i) == A_PIPE0 + p);
    disp_pipe_stat u_pipe (
      .clk(clk), .rst_n(rst_n), .vbs_i(vbs_i[p]), .vb_i(vb_i[p]),
      .wr_i(pwr), .wdata_i(reg_wdata_i[3:0]), .ctl_o(pctl_w[p]),
      .src_o(psrc_w[p]));
  end

  assign raw_w  = {psrc_w, blc_i, user_i};
  assign iclr_w = (reg_wen_i && int'(reg_addr_i) == A_IDENT)
                  ? reg_wdata_i[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (reg_wen_i && int'(reg_addr_i) == A_EN)   en_q   <= reg_wdata_i[NSRC-1:0];
      if (reg_wen_i && int'(reg_addr_i) == A_MASK) mask_q <= reg_wdata_i[NSRC-1:0];
      rdata_q <= rd_mux;
    end
  end

  disp_irq_ident #(.NSRC(NSRC)) u_ident (
    .clk(clk), .rst_n(rst_n), .src_i(raw_w), .mask_i(mask_q), .en_i(en_q),
    .clr_i(iclr_w), .ident_o(ident_w), .irq_o(irq_o));

  always_comb begin
    rd_mux = '0;
    case (int'(reg_addr_i))
      A_RAW:   rd_mux[NSRC-1:0] = raw_w;
      A_EN:    rd_mux[NSRC-1:0] = en_q;
      A_MASK:  rd_mux[NSRC-1:0] = mask_q;
      A_IDENT: rd_mux[NSRC-1:0] = ident_w;
      default: ;
    endcase
    for (int p = 0; p < NPIPE; p++)
      if (int'(reg_addr_i) == A_PIPE0 + p) rd_mux[3:0] = pctl_w[p];
  end

  assign reg_rdata_o = rdata_q;

  // R1 R8
  mask_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen_i && int'(reg_addr_i) == A_MASK) |=> ($past(ident_w) & ~ident_w) == '0);
endmodule

// File: tb/sim_disp_irq_ctrl.sv
module sim_disp_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [1:0] vbs = 0, vb = 0;
  logic user = 0, blc = 0, wen = 0, irq;
  logic [2:0] addr = 0;
  logic [3:0] wdata = 0, rdata;
  int nchk = 0, nfail = 0;
  bit done = 0;

  // model state
  logic [3:0] m_en, m_mask, m_ident;
  logic [1:0] m_pen [2], m_pst [2];
  logic m_prev [2];

  always #2.5 clk = ~clk;

  disp_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .vbs_i(vbs), .vb_i(vb),
    .user_i(user), .blc_i(blc), .reg_addr_i(addr), .reg_wen_i(wen),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic f_src(logic [1:0] en, logic [1:0] st);
    logic r = 1'b0;
    for (int k = 0; k < 2; k++) if (en[k] && st[k]) r = 1'b1;
    return r;
  endfunction

  function automatic logic f_irq(logic [3:0] id, logic [3:0] en);
    return (id & en) != 4'h0;
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [3:0] d);
    @(negedge clk); addr = 3'(a); wdata = d; wen = 1;
    @(negedge clk); wen = 0;
  endtask

  task automatic rd(int a, output logic [3:0] d);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); d = rdata;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic model_latch();
    for (int p = 0; p < 2; p++) begin
      logic now = f_src(m_pen[p], m_pst[p]);
      if (now && !m_prev[p] && !m_mask[2+p]) m_ident[2+p] = 1'b1;
      m_prev[p] = now;
    end
  endtask

  task automatic pulse(int p, int k);
    @(negedge clk); if (k == 0) vbs[p] = 1; else vb[p] = 1;
    @(negedge clk); vbs = 0; vb = 0;
    m_pst[p][k] = 1'b1; model_latch(); settle();
  endtask

  task automatic side_pulse(int which);
    @(negedge clk); if (which == 0) user = 1; else blc = 1;
    @(negedge clk); user = 0; blc = 0;
    if (!m_mask[which]) m_ident[which] = 1'b1;
    settle();
  endtask

  task automatic pwr(int p, logic [3:0] d);
    wr(4 + p, d); m_pen[p] = d[1:0]; m_pst[p] = m_pst[p] & ~d[3:2];
    model_latch(); settle();
  endtask

  task automatic check_all(string tag);
    logic [3:0] v;
    rd(3, v); chk({tag, " ident"}, v, m_ident);
    rd(0, v); chk({tag, " raw"}, v,
      {f_src(m_pen[1], m_pst[1]), f_src(m_pen[0], m_pst[0]), 2'b00});
    rd(4, v); chk({tag, " pipeA"}, v, {m_pst[0], m_pen[0]});
    rd(5, v); chk({tag, " pipeB"}, v, {m_pst[1], m_pen[1]});
    chk({tag, " irq"}, {3'b0, irq}, {3'b0, f_irq(m_ident, m_en)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    int unsigned seed;
    m_en = 0; m_mask = 4'hF; m_ident = 0;
    for (int p = 0; p < 2; p++) begin m_pen[p] = 0; m_pst[p] = 0; m_prev[p] = 0; end
    repeat (3) @(negedge clk); rst_n = 1;

    // R1 reset state, R12 read path
    rd(2, v); chk("R1 mask", v, 4'hF);
    rd(1, v); chk("R1 enable", v, 4'h0);
    check_all("R1");

    // R2 status sets with enables off; R5 raw stays low
    pulse(0, 0);
    check_all("R2 R5");
    wr(2, 4'h0); m_mask = 0;
    wr(1, 4'hF); m_en = 4'hF;
    rd(1, v); chk("R12 enable readback", v, 4'hF);
    pwr(0, 4'hC);
    check_all("R3 clear both");

    // R5 vb not enabled: no source; R6 vbs enabled: latch, R10 irq
    pwr(0, 4'h1);
    pulse(0, 1);
    check_all("R5 disabled bit");
    pulse(0, 0);
    check_all("R6 R10 latch");

    // R9 identity write-1-clear, zeros ignored
    wr(3, 4'h0); check_all("R9 zero write");
    wr(3, 4'h4); m_ident[2] = 0; check_all("R9 clear");

    // R6 no retrigger while source stays high
    pulse(0, 0); check_all("R6 held high");

    // R7 masked edge lost even after unmask
    pwr(0, 4'hD);
    wr(2, 4'h4); m_mask = 4'h4;
    pulse(0, 0); check_all("R7 masked");
    wr(2, 4'h0); m_mask = 0; settle(); check_all("R7 unmask");

    // R8 mask does not clear latched identity
    pwr(0, 4'hD); pulse(0, 0);
    wr(2, 4'h4); m_mask = 4'h4; settle(); check_all("R8 hold");

    // R10 irq follows enable
    wr(1, 4'h0); m_en = 0; settle(); check_all("R10 en off");
    wr(1, 4'h4); m_en = 4'h4; settle(); check_all("R10 en on");

    // R4 clear and event same cycle: event wins
    @(negedge clk); addr = 3'd4; wdata = 4'h5; wen = 1; vbs[0] = 1;
    @(negedge clk); wen = 0; vbs = 0; settle();
    rd(4, v); chk("R4 same cycle", v, 4'h5);
    // R3 zero in status field leaves it, one clears
    wr(4, 4'h1); rd(4, v); chk("R3 zero keeps", v, 4'h5);
    wr(4, 4'h5); rd(4, v); chk("R3 one clears", v, 4'h1);
    m_pen[0] = 2'b01; m_pst[0] = 0; m_prev[0] = 0;

    // R11 side sources
    wr(3, 4'hF); m_ident = 0;
    wr(2, 4'h0); m_mask = 0;
    side_pulse(0); check_all("R11 user");
    side_pulse(1); check_all("R11 backlight");
    wr(2, 4'h3); m_mask = 4'h3; wr(3, 4'h3); m_ident[1:0] = 0;
    side_pulse(0); check_all("R11 masked user");

    // random mix
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 80; i++) begin
      int op = $urandom_range(0, 5);
      logic [3:0] d = 4'($urandom_range(0, 15));
      case (op)
        0: pulse($urandom_range(0, 1), $urandom_range(0, 1));
        1: pwr($urandom_range(0, 1), d);
        2: begin wr(1, d); m_en = d; settle(); end
        3: begin wr(2, d); m_mask = d; settle(); end
        4: begin wr(3, d); m_ident = m_ident & ~d; settle(); end
        default: side_pulse($urandom_range(0, 1));
      endcase
      check_all("R6 R7 R9 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule